// File: doc/BRIEF.md
# Programmable Pin Interface Cell

This block sits between one device pin (or a small bundle of pins sharing one configuration) and the internal signal routing. A static configuration field picks how the pin is used: as an input passed straight through, as an input captured by an edge-triggered flip-flop, as an input captured by a level-sensitive transparent latch, as an output that always drives, or as a bidirectional pin whose driver is switched by enables. A separate bit picks the output polarity.

In the bidirectional mode the driver turns on only when a group-wide enable, shared by a set of neighbouring cells, and a local enable from the logic array are both high. The capture flip-flop and latch run from one of two I/O clock lines chosen by a small select field. An active-low reset clears both storage elements at once, without waiting for a clock.

Top module: `pio_cell`

## Requirements
- R1: The 3-bit `cfg_mode` field selects the use of the cell: 0 direct input, 1 flip-flop input, 2 latch input, 3 output only, 4 bidirectional; codes 5, 6 and 7 behave exactly as code 0.
- R2: In direct input mode `core_in` equals `pin_in` with no clock edge needed.
- R3: In flip-flop input mode `core_in` takes the value of `pin_in` at each rising edge of the selected I/O clock and does not change between edges.
- R4: In latch input mode `core_in` follows `pin_in` while the selected I/O clock is high and holds the last value while it is low.
- R5: While `rst_n` is low the flip-flop and the latch are cleared to 0 without any clock edge, so `core_in` reads 0 in modes 1 and 2.
- R6: In output-only mode `pin_oe` is 1 whatever the enables are, and `core_in` is 0.
- R7: In bidirectional mode `pin_oe` is 1 only when `grp_oe` and `pt_oe` are both 1, and `core_in` equals `pin_in` in every case.
- R8: In every input mode (codes 0, 1, 2, 5, 6, 7) `pin_oe` is 0 whatever the enables are.
- R9: `pin_out` equals `core_out` when `cfg_inv` is 0 and its complement when `cfg_inv` is 1.
- R10: `cfg_clksel` value 1 clocks the storage from `ioclk1`; values 0, 2 and 3 clock it from `ioclk0`; edges on the unselected line have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ioclk0 | input | 1 | I/O clock line 0 |
| ioclk1 | input | 1 | I/O clock line 1 |
| rst_n | input | 1 | Active-low reset of flip-flop and latch |
| cfg_mode | input | 3 | Use of the cell (encoding in R1) |
| cfg_inv | input | 1 | 1 inverts the driven data |
| cfg_clksel | input | 2 | I/O clock choice (encoding in R10) |
| core_out | input | DW | Data from the routing to drive onto the pin |
| pt_oe | input | 1 | Local output enable from the logic array |
| grp_oe | input | 1 | Output enable shared by the cell group |
| pin_in | input | DW | Level seen at the pin |
| pin_out | output | DW | Data to the pin driver |
| pin_oe | output | DW | Pin driver enable |
| core_in | output | DW | Data sent into the routing |

## Verification
The hardest case to reach is telling the two I/O clock lines apart: a wrong clock choice looks correct as long as both lines pulse together. The bench therefore drives each clock line by hand, one pulse at a time, changes the pin between pulses, and checks after each pulse that only the selected line moved the stored value, including for the reserved select codes. Latch transparency is reached the same way, by holding the selected clock high while the pin toggles and then low while it toggles again.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [2:0] {
        PM_DIRECT = 3'd0,
        PM_FLOP   = 3'd1,
        PM_LATCH  = 3'd2,
        PM_DRIVE  = 3'd3,
        PM_BIDIR  = 3'd4
    } pmode_e;

    // Decoded path controls for one configuration
    typedef struct packed {
        logic sel_flop;
        logic sel_latch;
        logic sel_zero;
        logic oe_always;
        logic oe_gated;
    } path_t;

endpackage

// File: rtl/pio_mode_dec.sv
module pio_mode_dec
    import pio_pkg::*;
(
    input  logic [2:0] cfg_mode,
    output path_t      path
);

    always_comb begin
        path = '0;
        unique case (cfg_mode)
            3'(PM_FLOP):  path.sel_flop  = 1'b1;
            3'(PM_LATCH): path.sel_latch = 1'b1;
            3'(PM_DRIVE): begin
                path.sel_zero  = 1'b1;
                path.oe_always = 1'b1;
            end
            3'(PM_BIDIR): path.oe_gated = 1'b1;
            default:      path = '0;
        endcase
    end

endmodule

// File: rtl/pio_clk_pick.sv
module pio_clk_pick #(
    parameter int SELW = 2
) (
    input  logic            ioclk0,
    input  logic            ioclk1,
    input  logic [SELW-1:0] cfg_clksel,
    output logic            clk_o
);

    localparam logic [SELW-1:0] PICK_ONE = SELW'(1);

    assign clk_o = (cfg_clksel == PICK_ONE) ? ioclk1 : ioclk0;

endmodule

// File: rtl/pio_capture.sv
module pio_capture #(
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] flop_q,
    output logic [DW-1:0] latch_q
);

    typedef struct packed {
        logic [DW-1:0] flop;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.flop = pin_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    // Level-sensitive capture: open while the clock is high
    always_latch begin
        if (!rst_n)   latch_q = '0;
        else if (clk) latch_q = pin_in;
    end

    assign flop_q = cap_q.flop;

endmodule

// File: rtl/pio_cell.sv
module pio_cell
    import pio_pkg::*;
#(
    parameter int DW   = 1,
    parameter int SELW = 2
) (
    input  logic            ioclk0,
    input  logic            ioclk1,
    input  logic            rst_n,
    input  logic [2:0]      cfg_mode,
    input  logic            cfg_inv,
    input  logic [SELW-1:0] cfg_clksel,
    input  logic [DW-1:0]   core_out,
    input  logic            pt_oe,
    input  logic            grp_oe,
    input  logic [DW-1:0]   pin_in,
    output logic [DW-1:0]   pin_out,
    output logic [DW-1:0]   pin_oe,
    output logic [DW-1:0]   core_in
);

    path_t         path;
    logic          io_clk;
    logic [DW-1:0] flop_q;
    logic [DW-1:0] latch_q;
    logic          drive_en;

    pio_mode_dec u_dec (
        .cfg_mode (cfg_mode),
        .path     (path)
    );

    pio_clk_pick #(.SELW(SELW)) u_clk (
        .ioclk0     (ioclk0),
        .ioclk1     (ioclk1),
        .cfg_clksel (cfg_clksel),
        .clk_o      (io_clk)
    );

    pio_capture #(.DW(DW)) u_cap (
        .clk     (io_clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .flop_q  (flop_q),
        .latch_q (latch_q)
    );

    assign drive_en = path.oe_always | (path.oe_gated & grp_oe & pt_oe);

    always_comb begin
        pin_oe  = {DW{drive_en}};
        pin_out = cfg_inv ? ~core_out : core_out;
        if (path.sel_zero)       core_in = '0;
        else if (path.sel_flop)  core_in = flop_q;
        else if (path.sel_latch) core_in = latch_q;
        else                     core_in = pin_in;
    end

endmodule

// File: rtl/pio_cell_chk.sv
module pio_cell_chk #(
    parameter int DW   = 1,
    parameter int SELW = 2
) (
    input logic            ioclk0,
    input logic            ioclk1,
    input logic            rst_n,
    input logic [2:0]      cfg_mode,
    input logic            cfg_inv,
    input logic [SELW-1:0] cfg_clksel,
    input logic [DW-1:0]   core_out,
    input logic            pt_oe,
    input logic            grp_oe,
    input logic [DW-1:0]   pin_in,
    input logic [DW-1:0]   pin_out,
    input logic [DW-1:0]   pin_oe,
    input logic [DW-1:0]   core_in
);

    logic          ck;
    logic          armed_q;
    logic [DW-1:0] seen_q;
    logic          in_mode;

    assign ck      = (cfg_clksel == SELW'(1)) ? ioclk1 : ioclk0;
    assign in_mode = (cfg_mode != 3'd3) && (cfg_mode != 3'd4);

    always_ff @(posedge ck or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            seen_q  <= '0;
        end else begin
            armed_q <= 1'b1;
            seen_q  <= pin_in;
        end
    end

    // R8
    input_no_drive_chk: assert property (@(posedge ioclk0) disable iff (!rst_n)
        in_mode |-> (pin_oe == '0));

    // R6
    output_drives_chk: assert property (@(posedge ioclk0) disable iff (!rst_n)
        (cfg_mode == 3'd3) |-> (pin_oe == '1) && (core_in == '0));

    // R7
    bidir_gate_chk: assert property (@(posedge ioclk0) disable iff (!rst_n)
        (cfg_mode == 3'd4 && pin_oe != '0) |-> (grp_oe && pt_oe));

    // R9
    polarity_chk: assert property (@(posedge ioclk0) disable iff (!rst_n)
        cfg_inv |-> ((pin_out & core_out) == '0));

    // R3
    flop_capture_chk: assert property (@(negedge ck) disable iff (!rst_n)
        (cfg_mode == 3'd1 && armed_q) |-> (core_in == seen_q));

    // R4
    latch_open_chk: assert property (@(negedge ck) disable iff (!rst_n)
        (cfg_mode == 3'd2) |-> (core_in == pin_in));

endmodule

bind pio_cell pio_cell_chk #(.DW(DW), .SELW(SELW)) u_chk (
    .ioclk0     (ioclk0),
    .ioclk1     (ioclk1),
    .rst_n      (rst_n),
    .cfg_mode   (cfg_mode),
    .cfg_inv    (cfg_inv),
    .cfg_clksel (cfg_clksel),
    .core_out   (core_out),
    .pt_oe      (pt_oe),
    .grp_oe     (grp_oe),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .core_in    (core_in)
);

// File: tb/sim_pio_cell.sv
module sim_pio_cell;

    localparam int CLK_NS = 10;
    localparam int NVEC   = 12;

    // {mode[2:0], inv, grp, pt, cout, pin, exp_oe, exp_out, exp_in}
    localparam logic [10:0] VEC [NVEC] = '{
        11'b000_0_1_1_1_1_0_1_1,  // R2 R8 direct input
        11'b000_1_1_1_1_0_0_0_0,  // R2 R8 R9
        11'b011_0_0_0_1_0_1_1_0,  // R6 drives with no enables
        11'b011_1_0_1_1_1_1_0_0,  // R6 R9 inverted
        11'b011_1_1_0_0_0_1_1_0,  // R6 R9
        11'b100_0_1_1_1_0_1_1_0,  // R7 both enables
        11'b100_0_1_0_1_1_0_1_1,  // R7 local enable low
        11'b100_0_0_1_0_1_0_0_1,  // R7 group enable low
        11'b100_1_1_1_0_1_1_1_1,  // R7 R9
        11'b100_1_0_0_1_0_0_0_0,  // R7 R9
        11'b101_0_1_1_1_1_0_1_1,  // R1 reserved code
        11'b111_1_1_1_0_0_0_1_0   // R1 R8 reserved code
    };

    logic       ioclk0, ioclk1, rst_n;
    logic [2:0] cfg_mode;
    logic       cfg_inv;
    logic [1:0] cfg_clksel;
    logic [0:0] core_out, pin_in, pin_out, pin_oe, core_in;
    logic       pt_oe, grp_oe;

    int n_chk = 0;
    int n_bad = 0;

    pio_cell #(.DW(1), .SELW(2)) u0 (
        .ioclk0     (ioclk0),
        .ioclk1     (ioclk1),
        .rst_n      (rst_n),
        .cfg_mode   (cfg_mode),
        .cfg_inv    (cfg_inv),
        .cfg_clksel (cfg_clksel),
        .core_out   (core_out),
        .pt_oe      (pt_oe),
        .grp_oe     (grp_oe),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .core_in    (core_in)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic pulse0();
        #(CLK_NS/2) ioclk0 = 1'b1;
        #(CLK_NS/2) ioclk0 = 1'b0;
        #1;
    endtask

    task automatic pulse1();
        #(CLK_NS/2) ioclk1 = 1'b1;
        #(CLK_NS/2) ioclk1 = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        ioclk0 = 0; ioclk1 = 0; rst_n = 0;
        cfg_mode = 3'd1; cfg_inv = 0; cfg_clksel = 2'd0;
        core_out = 0; pt_oe = 0; grp_oe = 0; pin_in = 1;
        #(CLK_NS);
        check("R5 reset clears flop", 8'(core_in), 8'd0);
        rst_n = 1; #1;

        for (int i = 0; i < NVEC; i++) begin
            {cfg_mode, cfg_inv, grp_oe, pt_oe, core_out, pin_in} = VEC[i][10:3];
            #2;
            check($sformatf("R1/R2/R6/R7/R8/R9 vector %0d", i),
                  {5'd0, pin_oe, pin_out, core_in}, {5'd0, VEC[i][2:0]});
            pulse0();
        end

        // R3 / R10 flip-flop with clock 0
        cfg_mode = 3'd1; cfg_clksel = 2'd0; pin_in = 1; #2;
        pulse0();
        check("R3 capture on clk0 edge", 8'(core_in), 8'd1);
        pin_in = 0; #2;
        check("R3 holds between edges", 8'(core_in), 8'd1);
        pulse1();
        check("R10 unselected ioclk1 ignored", 8'(core_in), 8'd1);
        pulse0();
        check("R3 capture 0 on clk0", 8'(core_in), 8'd0);

        // R10 select 1
        cfg_clksel = 2'd1; pin_in = 1; #2;
        pulse0();
        check("R10 sel1 ignores ioclk0", 8'(core_in), 8'd0);
        pulse1();
        check("R10 sel1 captures on ioclk1", 8'(core_in), 8'd1);

        // R10 reserved select 3
        cfg_clksel = 2'd3; pin_in = 0; #2;
        pulse1();
        check("R10 sel3 ignores ioclk1", 8'(core_in), 8'd1);
        pulse0();
        check("R10 sel3 uses ioclk0", 8'(core_in), 8'd0);

        // R5 asynchronous clear
        cfg_clksel = 2'd2; pin_in = 1; #2;
        pulse0();
        check("R10 sel2 uses ioclk0", 8'(core_in), 8'd1);
        rst_n = 0; #2;
        check("R5 async clear of flop", 8'(core_in), 8'd0);
        rst_n = 1; #2;

        // R4 latch mode
        cfg_mode = 3'd2; cfg_clksel = 2'd0; pin_in = 1; #2;
        check("R4 latch closed holds reset value", 8'(core_in), 8'd0);
        #1 ioclk0 = 1; #2;
        check("R4 latch open follows 1", 8'(core_in), 8'd1);
        pin_in = 0; #2;
        check("R4 latch open follows 0", 8'(core_in), 8'd0);
        pin_in = 1; #2;
        ioclk0 = 0; #2;
        pin_in = 0; #2;
        check("R4 latch closed holds 1", 8'(core_in), 8'd1);
        rst_n = 0; #2;
        check("R5 async clear of latch", 8'(core_in), 8'd0);
        rst_n = 1; #2;

        // R8 flip-flop and latch modes never drive
        grp_oe = 1; pt_oe = 1; cfg_mode = 3'd1; #2;
        check("R8 flop mode no drive", 8'(pin_oe), 8'd0);
        cfg_mode = 3'd2; #2;
        check("R8 latch mode no drive", 8'(pin_oe), 8'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule